// File: doc/BRIEF.md
# Translation Buffer with Access Permission Check

This block keeps a small set-associative store of recently used page translations for one requester. A lookup presents a virtual address, the owning process number and the kind of access (read, write or instruction fetch). In the same cycle the block answers in one of three ways. It returns the physical address on a permitted hit. It flags a protection fault when a matching entry exists but does not allow the access. It flags a miss when no entry matches.

On a miss, an external page walker takes the address and process number from the lookup port and later installs the result through the refill port. The block picks the way to use. A full flush clears every entry. A per-process flush clears only the entries owned by one process number.

The default geometry is 16 sets of 2 ways, 4 KB pages, a 32-bit virtual address and a 20-bit physical page number. One replacement bit per set chooses the victim.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss.
- R2: The page offset is vaddr[11:0], the set index is vaddr[15:12] and the tag is vaddr[31:16]. A permitted hit drives lk_paddr = {ppn, vaddr[11:0]}. In every other case lk_paddr is zero.
- R3: A hit requires both the tag and the process number to match. The same address under another process number misses.
- R4: Access codes are 0 read, 1 write, 2 fetch and 3 reserved. Permission bits are [0] read, [1] write and [2] fetch. A matching entry whose bit for the access is clear, or any reserved access, gives lk_fault. It never gives lk_hit or lk_miss.
- R5: At most one of lk_hit, lk_fault and lk_miss is high. The result depends only on the current lookup inputs and the stored state, so it is available in the same cycle.
- R6: lk_miss is high for a valid lookup that matches no valid entry.
- R7: A refill becomes visible to lookups from the next cycle. Refilling a tag and process number that are already present overwrites that same way and leaves the other way intact.
- R8: A refill goes into the matching way if there is one, otherwise into the first invalid way (way 0 first), otherwise into the victim way recorded for the set. Every refill, and every lookup that matches an entry, makes the other way the next victim.
- R9: lk_dirty shows the dirty bit of the matched entry. A refill loads that bit from rf_dirty. A permitted write hit sets it.
- R10: flush_all invalidates every entry by the next cycle.
- R11: A per-process flush invalidates only the entries whose process number equals flush_pid. All other entries stay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_pid | input | 4 | Process number of the lookup |
| lk_acc | input | 2 | Access kind |
| lk_hit | output | 1 | Permitted hit |
| lk_fault | output | 1 | Protection fault |
| lk_miss | output | 1 | No matching entry |
| lk_paddr | output | 32 | Physical address |
| lk_dirty | output | 1 | Dirty bit of the matched entry |
| rf_valid | input | 1 | Install an entry |
| rf_vpn | input | 20 | Virtual page number to install |
| rf_pid | input | 4 | Process number to install |
| rf_ppn | input | 20 | Physical page number |
| rf_perm | input | 3 | Permission bits |
| rf_dirty | input | 1 | Initial dirty bit |
| flush_all | input | 1 | Invalidate all entries |
| flush_pid_en | input | 1 | Invalidate the entries of one process |
| flush_pid | input | 4 | Process number to flush |

## Verification
The assertions assume that a refill, a flush and a state-changing lookup do not land in the same cycle. They also assume that a refill never creates a second copy of an entry that is already present. The stimulus meets these assumptions by sending refills and flushes in cycles of their own, with lk_valid low. Lookups are raised for one cycle only, between those operations. Every refill either targets a new tag and process pair or deliberately overwrites an existing one, and the block handles that case itself.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic fetch;
    logic wr;
    logic rd;
  } perm_t;
endpackage

// File: rtl/tlb_way_store.sv
module tlb_way_store #(
  parameter int SETS  = 16,
  parameter int TAG_W = 16,
  parameter int PID_W = 4,
  parameter int PPN_W = 20,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] look_idx,
  output logic             look_valid,
  output logic [TAG_W-1:0] look_tag,
  output logic [PID_W-1:0] look_pid,
  output logic [PPN_W-1:0] look_ppn,
  output logic [2:0]       look_perm,
  output logic             look_dirty,
  input  logic [IDX_W-1:0] fill_idx,
  output logic             fill_valid,
  output logic [TAG_W-1:0] fill_tag,
  output logic [PID_W-1:0] fill_pid,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [2:0]       wr_perm,
  input  logic             wr_dirty,
  input  logic             mark_en,
  input  logic             flush_all,
  input  logic             flush_pid_en,
  input  logic [PID_W-1:0] flush_pid
);
  logic [SETS-1:0]  valid_q, valid_d;
  logic [SETS-1:0]  dirty_q, dirty_d;
  logic [TAG_W-1:0] tag_q  [SETS];
  logic [PID_W-1:0] pid_q  [SETS];
  logic [PPN_W-1:0] ppn_q  [SETS];
  logic [2:0]       perm_q [SETS];

  assign look_valid = valid_q[look_idx];
  assign look_tag   = tag_q[look_idx];
  assign look_pid   = pid_q[look_idx];
  assign look_ppn   = ppn_q[look_idx];
  assign look_perm  = perm_q[look_idx];
  assign look_dirty = dirty_q[look_idx];
  assign fill_valid = valid_q[fill_idx];
  assign fill_tag   = tag_q[fill_idx];
  assign fill_pid   = pid_q[fill_idx];

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (flush_all) begin
      valid_d = '0;
    end else begin
      if (flush_pid_en) begin
        for (int s = 0; s < SETS; s++) begin
          if (pid_q[s] == flush_pid) valid_d[s] = 1'b0;
        end
      end
      if (wr_en) begin
        valid_d[fill_idx] = 1'b1;
        dirty_d[fill_idx] = wr_dirty;
      end else if (mark_en) begin
        dirty_d[look_idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush_all) begin
      tag_q[fill_idx]  <= wr_tag;
      pid_q[fill_idx]  <= wr_pid;
      ppn_q[fill_idx]  <= wr_ppn;
      perm_q[fill_idx] <= wr_perm;
    end
  end

  p_flush_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0));
  p_fill_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush_all && !flush_pid_en) |=> valid_q[$past(fill_idx)]);
  p_mark_dirty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_en && !wr_en && !flush_all) |=> dirty_q[$past(look_idx)]);
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int SETS = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_way,
  input  logic [IDX_W-1:0] query_idx,
  output logic             victim
);
  logic [SETS-1:0] lru_q, lru_d;

  assign victim = lru_q[query_idx];

  always_comb begin
    lru_d = lru_q;
    if (touch_en) lru_d[touch_idx] = ~touch_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru_q <= '0;
    else        lru_q <= lru_d;
  end

  p_lru_other_r8: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (lru_q[$past(touch_idx)] == ~$past(touch_way)));
endmodule

// File: rtl/tlb_check.sv
module tlb_check #(
  parameter int TAG_W = 16,
  parameter int PID_W = 4
) (
  input  logic             ent_valid,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [PID_W-1:0] ent_pid,
  input  logic [2:0]       ent_perm,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [PID_W-1:0] req_pid,
  input  logic [1:0]       req_acc,
  output logic             match,
  output logic             allow
);
  import tlb_pkg::*;
  perm_t perm;

  assign perm  = perm_t'(ent_perm);
  assign match = ent_valid && (ent_tag == req_tag) && (ent_pid == req_pid);

  always_comb begin
    unique case (acc_e'(req_acc))
      ACC_READ:  allow = perm.rd;
      ACC_WRITE: allow = perm.wr;
      ACC_FETCH: allow = perm.fetch;
      default:   allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PPN_W = 20,
  parameter int PID_W = 4,
  parameter int SETS  = 16,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = VPN_W - IDX_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [PID_W-1:0] lk_pid,
  input  logic [1:0]       lk_acc,
  output logic             lk_hit,
  output logic             lk_fault,
  output logic             lk_miss,
  output logic [PA_W-1:0]  lk_paddr,
  output logic             lk_dirty,
  input  logic             rf_valid,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [PID_W-1:0] rf_pid,
  input  logic [PPN_W-1:0] rf_ppn,
  input  logic [2:0]       rf_perm,
  input  logic             rf_dirty,
  input  logic             flush_all,
  input  logic             flush_pid_en,
  input  logic [PID_W-1:0] flush_pid
);
  import tlb_pkg::*;

  logic [IDX_W-1:0] lk_idx, rf_idx;
  logic [TAG_W-1:0] lk_tag, rf_tag;
  assign lk_idx = lk_vaddr[OFF_W +: IDX_W];
  assign lk_tag = lk_vaddr[VA_W-1 -: TAG_W];
  assign rf_idx = rf_vpn[IDX_W-1:0];
  assign rf_tag = rf_vpn[VPN_W-1 -: TAG_W];

  logic [WAYS-1:0]  e_valid, e_dirty, e_match, e_allow;
  logic [WAYS-1:0]  f_valid, f_match, wr_way, mark_way;
  logic [TAG_W-1:0] e_tag [WAYS];
  logic [TAG_W-1:0] f_tag [WAYS];
  logic [PID_W-1:0] e_pid [WAYS];
  logic [PID_W-1:0] f_pid [WAYS];
  logic [PPN_W-1:0] e_ppn [WAYS];
  logic [2:0]       e_perm [WAYS];

  logic sel_way, fill_way, victim, any_match, grant;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      tlb_way_store #(.SETS(SETS), .TAG_W(TAG_W), .PID_W(PID_W), .PPN_W(PPN_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .look_idx(lk_idx), .look_valid(e_valid[w]), .look_tag(e_tag[w]),
        .look_pid(e_pid[w]), .look_ppn(e_ppn[w]), .look_perm(e_perm[w]),
        .look_dirty(e_dirty[w]),
        .fill_idx(rf_idx), .fill_valid(f_valid[w]), .fill_tag(f_tag[w]),
        .fill_pid(f_pid[w]),
        .wr_en(wr_way[w]), .wr_tag(rf_tag), .wr_pid(rf_pid), .wr_ppn(rf_ppn),
        .wr_perm(rf_perm), .wr_dirty(rf_dirty),
        .mark_en(mark_way[w]),
        .flush_all(flush_all), .flush_pid_en(flush_pid_en), .flush_pid(flush_pid)
      );

      tlb_check #(.TAG_W(TAG_W), .PID_W(PID_W)) u_check (
        .ent_valid(e_valid[w]), .ent_tag(e_tag[w]), .ent_pid(e_pid[w]),
        .ent_perm(e_perm[w]), .req_tag(lk_tag), .req_pid(lk_pid),
        .req_acc(lk_acc), .match(e_match[w]), .allow(e_allow[w])
      );

      assign f_match[w]  = f_valid[w] && (f_tag[w] == rf_tag) && (f_pid[w] == rf_pid);
      assign wr_way[w]   = rf_valid && (fill_way == w[0]);
      assign mark_way[w] = lk_hit && (acc_e'(lk_acc) == ACC_WRITE) && (sel_way == w[0]);
    end
  endgenerate

  // lookup result
  assign any_match = |e_match;
  assign sel_way   = e_match[1];
  assign grant     = e_allow[sel_way];

  always_comb begin
    lk_hit   = lk_valid && any_match && grant;
    lk_fault = lk_valid && any_match && !grant;
    lk_miss  = lk_valid && !any_match;
    lk_paddr = lk_hit ? {e_ppn[sel_way], lk_vaddr[OFF_W-1:0]} : '0;
    lk_dirty = lk_valid && any_match && e_dirty[sel_way];
  end

  // refill placement: existing copy, then first free way, then victim
  always_comb begin
    if (|f_match)        fill_way = f_match[1];
    else if (!f_valid[0]) fill_way = 1'b0;
    else if (!f_valid[1]) fill_way = 1'b1;
    else                  fill_way = victim;
  end

  logic             touch_en, touch_way;
  logic [IDX_W-1:0] touch_idx;
  always_comb begin
    touch_en  = rf_valid || (lk_valid && any_match);
    touch_idx = rf_valid ? rf_idx : lk_idx;
    touch_way = rf_valid ? fill_way : sel_way;
  end

  tlb_lru #(.SETS(SETS)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .touch_en(touch_en), .touch_idx(touch_idx), .touch_way(touch_way),
    .query_idx(rf_idx), .victim(victim)
  );

  p_one_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_fault, lk_miss}));
  p_unique_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(e_match));
  p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));
  p_fault_no_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fault || lk_miss) |-> (lk_paddr == '0));
endmodule

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic [3:0]  lk_pid;
  logic [1:0]  lk_acc;
  logic        lk_hit, lk_fault, lk_miss, lk_dirty;
  logic [31:0] lk_paddr;
  logic        rf_valid;
  logic [19:0] rf_vpn;
  logic [3:0]  rf_pid;
  logic [19:0] rf_ppn;
  logic [2:0]  rf_perm;
  logic        rf_dirty;
  logic        flush_all, flush_pid_en;
  logic [3:0]  flush_pid;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tlb_xlate uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid), .lk_acc(lk_acc),
    .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_miss(lk_miss),
    .lk_paddr(lk_paddr), .lk_dirty(lk_dirty),
    .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_pid(rf_pid), .rf_ppn(rf_ppn),
    .rf_perm(rf_perm), .rf_dirty(rf_dirty),
    .flush_all(flush_all), .flush_pid_en(flush_pid_en), .flush_pid(flush_pid)
  );

  function automatic logic [19:0] ppn_of(logic [19:0] vpn, logic [3:0] pid);
    return (vpn * 20'd7 + {16'd0, pid} + 20'h00100) & 20'hFFFFF;
  endfunction

  task automatic refill(logic [19:0] vpn, logic [3:0] pid, logic [19:0] ppn,
                        logic [2:0] perm, logic dirty);
    @(negedge clk);
    rf_valid = 1'b1; rf_vpn = vpn; rf_pid = pid; rf_ppn = ppn;
    rf_perm = perm; rf_dirty = dirty;
    @(negedge clk);
    rf_valid = 1'b0;
  endtask

  task automatic flush(logic all, logic [3:0] pid);
    @(negedge clk);
    flush_all = all; flush_pid_en = !all; flush_pid = pid;
    @(negedge clk);
    flush_all = 1'b0; flush_pid_en = 1'b0;
  endtask

  // kind: 0 hit, 1 fault, 2 miss; exp_dirty < 0 means not compared
  task automatic look(string req, logic [31:0] va, logic [3:0] pid, logic [1:0] acc,
                      int kind, logic [31:0] exp_pa, int exp_dirty);
    logic [2:0]  got, want;
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_pid = pid; lk_acc = acc;
    #1;
    got  = {lk_hit, lk_fault, lk_miss};
    want = (kind == 0) ? 3'b100 : (kind == 1) ? 3'b010 : 3'b001;
    checks++;
    if (got !== want || lk_paddr !== exp_pa ||
        (exp_dirty >= 0 && lk_dirty !== exp_dirty[0])) begin
      fails++;
      $display("FAIL %s va=%h pid=%0d acc=%0d: hit/fault/miss=%b paddr=%h dirty=%b expected %b paddr=%h dirty=%0d",
               req, va, pid, acc, got, lk_paddr, lk_dirty, want, exp_pa, exp_dirty);
    end
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  function automatic logic [31:0] va_of(logic [15:0] tag, logic [3:0] idx, logic [11:0] off);
    return {tag, idx, off};
  endfunction

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: run still active, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_vaddr = '0; lk_pid = '0; lk_acc = '0;
    rf_valid = 1'b0; rf_vpn = '0; rf_pid = '0; rf_ppn = '0; rf_perm = '0; rf_dirty = 1'b0;
    flush_all = 1'b0; flush_pid_en = 1'b0; flush_pid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    for (int s = 0; s < 16; s++)
      look("R1", va_of(16'h1234, s[3:0], 12'h0), 4'd3, 2'd0, 2, 32'h0, -1);

    // R2 R6 R7 R8: fill both ways of every set, then check all translations
    for (int s = 0; s < 16; s++) begin
      refill({16'h00A0, s[3:0]}, 4'd3, ppn_of({16'h00A0, s[3:0]}, 4'd3), 3'b111, 1'b0);
      refill({16'h00B0 + 16'(s), s[3:0]}, 4'd3, ppn_of({16'h00B0 + 16'(s), s[3:0]}, 4'd3), 3'b111, 1'b0);
    end
    for (int s = 0; s < 16; s++) begin
      logic [11:0] off;
      off = 12'((s * 37 + 5) & 12'hFFF);
      look("R2", va_of(16'h00A0, s[3:0], off), 4'd3, 2'd0, 0,
           {ppn_of({16'h00A0, s[3:0]}, 4'd3), off}, 0);
      look("R7", va_of(16'h00B0 + 16'(s), s[3:0], off), 4'd3, 2'd2, 0,
           {ppn_of({16'h00B0 + 16'(s), s[3:0]}, 4'd3), off}, 0);
      look("R6", va_of(16'h00C0, s[3:0], off), 4'd3, 2'd0, 2, 32'h0, -1);
      // R3: same address under another process number
      look("R3", va_of(16'h00A0, s[3:0], off), 4'd4, 2'd0, 2, 32'h0, -1);
    end

    // R9: write hit marks dirty, read afterwards shows it
    look("R9", va_of(16'h00A0, 4'd2, 12'h010), 4'd3, 2'd1, 0,
         {ppn_of({16'h00A0, 4'd2}, 4'd3), 12'h010}, 0);
    look("R9", va_of(16'h00A0, 4'd2, 12'h020), 4'd3, 2'd0, 0,
         {ppn_of({16'h00A0, 4'd2}, 4'd3), 12'h020}, 1);
    look("R9", va_of(16'h00B2, 4'd2, 12'h020), 4'd3, 2'd0, 0,
         {ppn_of({16'h00B2, 4'd2}, 4'd3), 12'h020}, 0);

    // R10: flush everything
    flush(1'b1, 4'd0);
    for (int s = 0; s < 16; s++)
      look("R10", va_of(16'h00A0, s[3:0], 12'h0), 4'd3, 2'd0, 2, 32'h0, -1);

    // R4: every permission set against every access kind
    for (int p = 0; p < 8; p++)
      refill({16'h0ABC, p[3:0]}, 4'd1, ppn_of({16'h0ABC, p[3:0]}, 4'd1), p[2:0], 1'b1);
    for (int p = 0; p < 8; p++)
      for (int a = 0; a < 4; a++) begin
        logic ok;
        ok = (a < 3) && p[a];
        look("R4", va_of(16'h0ABC, p[3:0], 12'h3C4), 4'd1, a[1:0], ok ? 0 : 1,
             ok ? {ppn_of({16'h0ABC, p[3:0]}, 4'd1), 12'h3C4} : 32'h0, 1);
      end

    // R8: victim follows the last use
    flush(1'b1, 4'd0);
    refill({16'h0011, 4'd3}, 4'd2, 20'h11111, 3'b001, 1'b0);
    refill({16'h0022, 4'd3}, 4'd2, 20'h22222, 3'b001, 1'b0);
    look("R8", va_of(16'h0011, 4'd3, 12'h0), 4'd2, 2'd0, 0, {20'h11111, 12'h0}, 0);
    refill({16'h0033, 4'd3}, 4'd2, 20'h33333, 3'b001, 1'b0);
    look("R8", va_of(16'h0011, 4'd3, 12'h1), 4'd2, 2'd0, 0, {20'h11111, 12'h1}, 0);
    look("R8", va_of(16'h0022, 4'd3, 12'h1), 4'd2, 2'd0, 2, 32'h0, -1);
    look("R8", va_of(16'h0033, 4'd3, 12'h1), 4'd2, 2'd0, 0, {20'h33333, 12'h1}, 0);
    // without a lookup, the older refill is the victim
    refill({16'h0044, 4'd6}, 4'd2, 20'h44444, 3'b001, 1'b0);
    refill({16'h0055, 4'd6}, 4'd2, 20'h55555, 3'b001, 1'b0);
    refill({16'h0066, 4'd6}, 4'd2, 20'h66666, 3'b001, 1'b0);
    look("R8", va_of(16'h0044, 4'd6, 12'h0), 4'd2, 2'd0, 2, 32'h0, -1);
    look("R8", va_of(16'h0055, 4'd6, 12'h0), 4'd2, 2'd0, 0, {20'h55555, 12'h0}, 0);

    // R7: overwrite of an existing pair stays in its way
    refill({16'h0077, 4'd9}, 4'd2, 20'h07000, 3'b001, 1'b0);
    refill({16'h0088, 4'd9}, 4'd2, 20'h08000, 3'b001, 1'b0);
    refill({16'h0077, 4'd9}, 4'd2, 20'h07777, 3'b011, 1'b1);
    look("R7", va_of(16'h0077, 4'd9, 12'h5), 4'd2, 2'd0, 0, {20'h07777, 12'h5}, 1);
    look("R7", va_of(16'h0088, 4'd9, 12'h5), 4'd2, 2'd0, 0, {20'h08000, 12'h5}, 0);

    // R11: per-process flush
    refill({16'h0099, 4'd5}, 4'd1, 20'h0A001, 3'b001, 1'b0);
    refill({16'h0099, 4'd5}, 4'd2, 20'h0A002, 3'b001, 1'b0);
    flush(1'b0, 4'd1);
    look("R11", va_of(16'h0099, 4'd5, 12'h0), 4'd1, 2'd0, 2, 32'h0, -1);
    look("R11", va_of(16'h0099, 4'd5, 12'h0), 4'd2, 2'd0, 0, {20'h0A002, 12'h0}, 0);
    look("R11", va_of(16'h0077, 4'd9, 12'h0), 4'd2, 2'd0, 0, {20'h07777, 12'h0}, 1);

    // R5: idle lookup port gives no result
    @(negedge clk);
    checks++;
    if ({lk_hit, lk_fault, lk_miss} !== 3'b000) begin
      fails++;
      $display("FAIL R5 idle: hit/fault/miss=%b expected 000", {lk_hit, lk_fault, lk_miss});
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule